// File: doc/BRIEF.md
# Exception and Supervisor-State Unit

This unit sits beside the execute stage of a small in-order 64-bit core. It takes exceptions and keeps the few supervisor registers that exception entry and return need. These are a machine-state word (MSR), a down-counting decrementer, and a pair of save/restore registers: SAVE_PC holds the resume address and SAVE_MSR holds the saved MSR. Each cycle the decode stage presents at most one classified operation, together with the address of the instruction it belongs to and an operand from the register file. When control flow must change, the unit answers one cycle later with a redirect strobe and a target address.

Entry into an exception takes two cycles. In the cycle the exception is taken, the unit captures SAVE_PC and clears the interrupt-enable bit of the MSR. In the following cycle it writes SAVE_MSR from a copy of the MSR taken before that bit was cleared. During that second cycle the unit raises `busy` and accepts nothing.

Three exceptions are supported. An illegal operation goes to a program-check vector, a system call goes to its own vector, and the decrementer goes to a third vector. The decrementer can interrupt only while its top bit is set and the MSR enable bit is 1. Only that one MSR bit has any effect; the other MSR bits are stored and read back unchanged.

Top module: `exc_sup_unit`

## Requirements
- R1: An accepted illegal operation (`op_kind`=1) produces `redir_valid`=1 with `redir_pc`=0x700 in the next cycle, and SAVE_PC receives `cur_pc` of that operation.
- R2: An accepted system call (`op_kind`=2) produces a redirect to 0xC00 in the next cycle, and SAVE_PC receives `cur_pc`+4.
- R3: The decrementer interrupt is pending while bit 63 of the decrementer is 1. It is taken in a cycle where `busy`=0, MSR bit 15 is 1, and no illegal operation or system call is accepted in the same cycle. It redirects to 0x900 in the next cycle and stores `cur_pc` into SAVE_PC. Any other operation presented in that cycle is discarded.
- R4: Exception entry takes two cycles. SAVE_PC is written at the entry edge. SAVE_MSR is written at the next edge with the MSR value from before entry. `busy` is 1 for exactly the one cycle after entry, and an operation presented in that cycle is ignored.
- R5: Taking any exception clears MSR bit 15 and leaves every other MSR bit unchanged.
- R6: A move-to-MSR (`op_kind`=4) writes all 64 bits from `wr_data`. While a move-from-MSR (`op_kind`=5) is presented with `busy`=0, `rd_data` shows the whole MSR; at all other times `rd_data` is zero.
- R7: MSR bits other than bit 15 have no effect: with bit 15 clear and the decrementer negative, no redirect occurs.
- R8: A move-to-decrementer (`op_kind`=6) loads `wr_data`. Otherwise the decrementer decreases by one in each cycle where `tick_en`=1. When a load and a tick fall in the same cycle, the load wins.
- R9: A return-from-interrupt (`op_kind`=3) produces a redirect to SAVE_PC in the next cycle and loads the MSR from SAVE_MSR at the same edge.
- R10: After reset the MSR, decrementer, SAVE_PC and SAVE_MSR are zero, and `busy` and `redir_valid` are 0. `op_kind` 0 means no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Decrementer count enable |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 3 | Operation class (encoding in R10, R1-style list in requirements) |
| cur_pc | input | 64 | Address of the presented instruction |
| wr_data | input | 64 | Operand for move-to-MSR and move-to-decrementer |
| rd_data | output | 64 | MSR value for move-from-MSR, else zero |
| busy | output | 1 | Second cycle of exception entry; no operation accepted |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 64 | Redirect target |

## Verification
The properties assume that decode never presents an operation and expects it to be acted upon while `busy` is high. They also assume `op_kind` carries only the seven defined codes. The stimulus uses only those codes and checks the reference model against the `busy` output before it relies on an operation taking effect. Operations that do fall into the busy cycle are sent on purpose, to show that they are dropped. `tick_en` is held low except in the decrementer sequences, so the counter stays positive while the enable bit is set in unrelated tests.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_ILLEGAL = 3'd1,
    OP_SYSCALL = 3'd2,
    OP_RFI     = 3'd3,
    OP_MTMSR   = 3'd4,
    OP_MFMSR   = 3'd5,
    OP_MTDEC   = 3'd6
  } op_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SAVE1 = 1'b1
  } seq_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_PROG = 2'd1,
    CAUSE_SC   = 2'd2,
    CAUSE_DEC  = 2'd3
  } cause_e;
endpackage

// File: rtl/exc_decrementer.sv
module exc_decrementer #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic         pending
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_en | tick_en;
    cnt_d  = load_en ? load_val : (cnt_q - {{(W-1){1'b0}}, 1'b1});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign pending = cnt_q[W-1];
endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int             W          = 64,
  parameter logic [W-1:0]   PROG_VEC   = 64'h700,
  parameter logic [W-1:0]   SC_VEC     = 64'hC00,
  parameter logic [W-1:0]   DEC_VEC    = 64'h900,
  parameter int             INSN_BYTES = 4
) (
  input  logic         busy,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] cur_pc,
  input  logic         msr_ee,
  input  logic         dec_pending,
  output logic         take_exc,
  output cause_e       cause,
  output logic [W-1:0] vec,
  output logic [W-1:0] save_pc,
  output logic         do_rfi,
  output logic         do_mtmsr,
  output logic         do_mtdec,
  output logic         do_mfmsr
);
  localparam logic [W-1:0] STEP = W'(INSN_BYTES);

  op_e  op;
  logic accept, is_prog, is_sc, is_dec, normal_ok;

  always_comb begin
    op        = op_e'(op_kind);
    accept    = op_valid && !busy;
    is_prog   = accept && (op == OP_ILLEGAL);
    is_sc     = accept && (op == OP_SYSCALL);
    is_dec    = !busy && msr_ee && dec_pending && !is_prog && !is_sc;
    take_exc  = is_prog | is_sc | is_dec;
    normal_ok = accept && !is_dec;
    do_rfi    = normal_ok && (op == OP_RFI);
    do_mtmsr  = normal_ok && (op == OP_MTMSR);
    do_mtdec  = normal_ok && (op == OP_MTDEC);
    do_mfmsr  = accept && (op == OP_MFMSR);

    cause   = CAUSE_NONE;
    vec     = '0;
    save_pc = cur_pc;
    if (is_prog) begin
      cause = CAUSE_PROG;
      vec   = PROG_VEC;
    end else if (is_sc) begin
      cause   = CAUSE_SC;
      vec     = SC_VEC;
      save_pc = cur_pc + STEP;
    end else if (is_dec) begin
      cause = CAUSE_DEC;
      vec   = DEC_VEC;
    end
  end
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int W      = 64,
  parameter int EE_BIT = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take_exc,
  input  logic [W-1:0] vec,
  input  logic [W-1:0] save_pc,
  input  logic         do_rfi,
  input  logic         do_mtmsr,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] msr_q,
  output logic [W-1:0] srr0_q,
  output logic         busy,
  output logic         redir_valid,
  output logic [W-1:0] redir_pc
);
  seq_e         st_q, st_d;
  logic [W-1:0] msr_d, srr1_q, hold_q;
  logic         msr_en, srr0_en, srr1_en, hold_en;
  logic         rv_d;
  logic [W-1:0] rpc_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SEQ_IDLE:  if (take_exc) st_d = SEQ_SAVE1;
      SEQ_SAVE1: st_d = SEQ_IDLE;
      default:   st_d = SEQ_IDLE;
    endcase

    msr_en = take_exc | do_rfi | do_mtmsr;
    msr_d  = msr_q;
    if (take_exc)      msr_d[EE_BIT] = 1'b0;
    else if (do_rfi)   msr_d = srr1_q;
    else if (do_mtmsr) msr_d = wr_data;

    srr0_en = take_exc;
    hold_en = take_exc;
    srr1_en = (st_q == SEQ_SAVE1);

    rv_d  = take_exc | do_rfi;
    rpc_d = take_exc ? vec : (do_rfi ? srr0_q : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= SEQ_IDLE;
      msr_q       <= '0;
      srr0_q      <= '0;
      srr1_q      <= '0;
      hold_q      <= '0;
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      st_q        <= st_d;
      redir_valid <= rv_d;
      redir_pc    <= rpc_d;
      if (msr_en)  msr_q  <= msr_d;
      if (srr0_en) srr0_q <= save_pc;
      if (hold_en) hold_q <= msr_q;
      if (srr1_en) srr1_q <= hold_q;
    end
  end

  assign busy = (st_q == SEQ_SAVE1);
endmodule

// File: rtl/exc_sup_unit.sv
module exc_sup_unit
  import exc_pkg::*;
#(
  parameter int           W          = 64,
  parameter int           EE_BIT     = 15,
  parameter int           INSN_BYTES = 4,
  parameter logic [W-1:0] PROG_VEC   = 64'h700,
  parameter logic [W-1:0] SC_VEC     = 64'hC00,
  parameter logic [W-1:0] DEC_VEC    = 64'h900
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         op_valid,
  input  logic [2:0]   op_kind,
  input  logic [W-1:0] cur_pc,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  output logic         busy,
  output logic         redir_valid,
  output logic [W-1:0] redir_pc
);
  logic         take_exc, do_rfi, do_mtmsr, do_mtdec, do_mfmsr, dec_pending;
  cause_e       cause;
  logic [W-1:0] vec, save_pc, msr_q, srr0_q;

  exc_arbiter #(
    .W(W), .PROG_VEC(PROG_VEC), .SC_VEC(SC_VEC), .DEC_VEC(DEC_VEC),
    .INSN_BYTES(INSN_BYTES)
  ) u_arb (
    .busy(busy), .op_valid(op_valid), .op_kind(op_kind), .cur_pc(cur_pc),
    .msr_ee(msr_q[EE_BIT]), .dec_pending(dec_pending),
    .take_exc(take_exc), .cause(cause), .vec(vec), .save_pc(save_pc),
    .do_rfi(do_rfi), .do_mtmsr(do_mtmsr), .do_mtdec(do_mtdec),
    .do_mfmsr(do_mfmsr)
  );

  exc_decrementer #(.W(W)) u_dec (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load_en(do_mtdec),
    .load_val(wr_data), .pending(dec_pending)
  );

  exc_state #(.W(W), .EE_BIT(EE_BIT)) u_st (
    .clk(clk), .rst_n(rst_n), .take_exc(take_exc), .vec(vec),
    .save_pc(save_pc), .do_rfi(do_rfi), .do_mtmsr(do_mtmsr),
    .wr_data(wr_data), .msr_q(msr_q), .srr0_q(srr0_q), .busy(busy),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  assign rd_data = do_mfmsr ? msr_q : '0;
endmodule

// File: rtl/exc_sup_unit_chk.sv
module exc_sup_unit_chk #(
  parameter int           W       = 64,
  parameter int           EE_BIT  = 15,
  parameter logic [W-1:0] DEC_VEC = 64'h900
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         take_exc,
  input logic         cause_dec,
  input logic         redir_valid,
  input logic [W-1:0] redir_pc,
  input logic [W-1:0] msr_q,
  input logic [W-1:0] srr0_q
);
  assert_redirect_on_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> redir_valid);
  assert_dec_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && cause_dec) |=> (redir_valid && redir_pc == DEC_VEC));
  assert_busy_after_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> busy);
  assert_busy_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  assert_no_entry_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take_exc);
  assert_save_pc_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(srr0_q));
  assert_ee_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |=> !msr_q[EE_BIT]);
endmodule

bind exc_sup_unit exc_sup_unit_chk #(.W(W), .EE_BIT(EE_BIT), .DEC_VEC(DEC_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .take_exc(take_exc),
  .cause_dec(cause == exc_pkg::CAUSE_DEC), .redir_valid(redir_valid),
  .redir_pc(redir_pc), .msr_q(msr_q), .srr0_q(srr0_q)
);

// File: tb/exc_sup_unit_test.sv
module exc_sup_unit_test;
  localparam logic [2:0] K_NONE = 3'd0, K_ILL = 3'd1, K_SC = 3'd2, K_RFI = 3'd3,
                         K_MTMSR = 3'd4, K_MFMSR = 3'd5, K_MTDEC = 3'd6;
  localparam int EE = 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, op_valid;
  logic [2:0]  op_kind;
  logic [63:0] cur_pc, wr_data, rd_data, redir_pc;
  logic        busy, redir_valid;

  int vectors = 0;
  int fails   = 0;

  // behavioural reference state
  logic [63:0] m_msr, m_srr0, m_srr1, m_hold, m_dec, e_rpc;
  bit          m_busy, e_rv;

  always #4 clk = ~clk;

  exc_sup_unit uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .op_valid(op_valid),
    .op_kind(op_kind), .cur_pc(cur_pc), .wr_data(wr_data), .rd_data(rd_data),
    .busy(busy), .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_advance(input logic v, input logic [2:0] k,
                               input logic [63:0] pc, input logic [63:0] wd, input logic tk);
    bit acc, ill, sc, dfire, exc;
    logic [63:0] n_msr, n_srr0, n_srr1, n_hold, n_dec;
    bit n_busy;
    acc   = v && !m_busy;
    ill   = acc && k == K_ILL;
    sc    = acc && k == K_SC;
    dfire = !m_busy && m_msr[EE] && m_dec[63] && !ill && !sc;
    exc   = ill || sc || dfire;
    n_msr = m_msr; n_srr0 = m_srr0; n_srr1 = m_srr1; n_hold = m_hold; n_dec = m_dec;
    n_busy = 0; e_rv = 0; e_rpc = 0;
    if (exc) begin
      n_srr0 = sc ? pc + 64'd4 : pc;
      n_hold = m_msr;
      n_msr[EE] = 1'b0;
      n_busy = 1;
      e_rv = 1;
      e_rpc = ill ? 64'h700 : (sc ? 64'hC00 : 64'h900);
    end else if (acc) begin
      if (k == K_RFI)   begin n_msr = m_srr1; e_rv = 1; e_rpc = m_srr0; end
      if (k == K_MTMSR) n_msr = wd;
    end
    if (m_busy) n_srr1 = m_hold;
    if (acc && !exc && k == K_MTDEC) n_dec = wd;
    else if (tk) n_dec = m_dec - 64'd1;
    m_msr = n_msr; m_srr0 = n_srr0; m_srr1 = n_srr1; m_hold = n_hold;
    m_dec = n_dec; m_busy = n_busy;
  endtask

  task automatic step(input logic v, input logic [2:0] k, input logic [63:0] pc,
                      input logic [63:0] wd, input logic tk, input string tag);
    op_valid = v; op_kind = k; cur_pc = pc; wr_data = wd; tick_en = tk;
    #1;
    chk("R4 busy", {63'd0, busy}, {63'd0, m_busy});
    chk("R6 rd_data", rd_data, (v && !m_busy && k == K_MFMSR) ? m_msr : 64'd0);
    model_advance(v, k, pc, wd, tk);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " redir_valid"}, {63'd0, redir_valid}, {63'd0, e_rv});
    if (e_rv) chk({tag, " redir_pc"}, redir_pc, e_rpc);
  endtask

  task automatic idle(input int n, input logic tk, input string tag);
    for (int i = 0; i < n; i++) step(0, K_NONE, 64'h0, 64'h0, tk, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 0; op_kind = K_NONE; cur_pc = 0; wr_data = 0; tick_en = 0;
    m_msr = 0; m_srr0 = 0; m_srr1 = 0; m_hold = 0; m_dec = 0; m_busy = 0; e_rv = 0; e_rpc = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 busy in reset", {63'd0, busy}, 64'd0);
    chk("R10 redir in reset", {63'd0, redir_valid}, 64'd0);
    rst_n = 1'b1;
    idle(2, 0, "R10");
    step(1, K_MFMSR, 64'h10, 0, 0, "R10 msr zero");

    // R6: full MSR write/read
    step(1, K_MTMSR, 64'h20, 64'hA5A5_0000_0000_9234, 0, "R6");
    step(1, K_MFMSR, 64'h24, 0, 0, "R6");

    // R1, R4, R5: program check, op in busy cycle ignored
    step(1, K_ILL, 64'h1000, 0, 0, "R1");
    step(1, K_MTMSR, 64'h1004, 64'hFFFF, 0, "R4 ignored");
    step(1, K_MFMSR, 64'h700, 0, 0, "R5 ee cleared");
    step(1, K_MTMSR, 64'h704, 64'h0, 0, "R6");
    // R9: return restores MSR from SAVE_MSR, goes to SAVE_PC
    step(1, K_RFI, 64'h708, 0, 0, "R9");
    step(1, K_MFMSR, 64'h1000, 0, 0, "R9 msr restored R4");

    // R2: system call
    step(1, K_MTMSR, 64'h1F00, 64'h0, 0, "R6");
    step(1, K_SC, 64'h2000, 0, 0, "R2");
    idle(1, 0, "R4");
    step(1, K_RFI, 64'hC00, 0, 0, "R2 return pc+4");

    // R7: all other bits set, EE clear, decrementer negative
    step(1, K_MTMSR, 64'h2004, ~(64'd1 << EE), 0, "R7");
    step(1, K_MTDEC, 64'h2008, 64'd1, 1, "R8 load over tick");
    idle(5, 1, "R7 no interrupt");

    // R3 / R8: countdown then interrupt
    step(1, K_MTMSR, 64'h3000, 64'd1 << EE, 0, "R6");
    step(1, K_MTDEC, 64'h3004, 64'd5, 1, "R8");
    idle(10, 1, "R3 R8 countdown");
    step(1, K_MFMSR, 64'h900, 0, 0, "R5");
    // return with EE=1 while still pending; illegal in same cycle wins
    step(1, K_RFI, 64'h904, 0, 0, "R9");
    step(1, K_ILL, 64'h4000, 0, 0, "R3 illegal wins");
    idle(1, 0, "R4");
    step(1, K_MFMSR, 64'h700, 0, 0, "R5");
    // decrementer still negative; enable again, next op is squashed
    step(1, K_MTMSR, 64'h704, 64'd1 << EE, 0, "R6");
    step(1, K_MTMSR, 64'h5000, 64'hFF00, 0, "R3 squash");
    idle(1, 0, "R4");
    step(1, K_MFMSR, 64'h900, 0, 0, "R3 squashed write");
    // reload positive and confirm no interrupt with EE set
    step(1, K_MTDEC, 64'h904, 64'd100, 0, "R8");
    step(1, K_MTMSR, 64'h908, 64'd1 << EE, 0, "R6");
    idle(6, 1, "R8 positive");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule